// File: doc/BRIEF.md
# Phase Bisection Solver

This block finds the phase of one fringe profile. A detrend stage upstream supplies three values for each profile: a sine-weighted sum S, a cosine-weighted sum C and an amplitude estimate A. The phase circle [−π, π) is split into NBS = 2^IDX_W equal steps, with index 0 at −π. For each step k, three preloaded tables hold cos θk, sin θk and a second-harmonic term H[k]. The block looks for the index at which the residual F(k) = cos[k]·S + sin[k]·C − A·H[k] crosses zero. It needs no divider and no trigonometric hardware: each probe costs one table read and three multiplications.

The search brackets the whole range, then halves the bracket at the midpoint index until two neighbouring indices remain. It reports whichever of the two has the smaller |F|. The maximum quantisation error is therefore π/NBS. One shared evaluator serves every probe, and a new profile is taken only after the previous result has been consumed. Inputs and results travel on valid/ready streams. A result stays on the output unchanged for as long as `out_ready` is low. While a search or an unconsumed result is pending, `in_ready` is low and `busy` is high, and the upstream stage must hold its data. The tables are written through a plain synchronous write port, one entry per cycle.

Top module: `phase_bisect`

## Requirements
- R1: After reset, `out_valid` is 0, `busy` is 0 and `in_ready` is 1.
- R2: A profile is accepted on a rising edge where `in_valid` and `in_ready` are both 1. From the next cycle until its result is consumed, `busy` is 1 and `in_ready` is 0.
- R3: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_index` and `out_id` hold their values. A result is consumed on an edge where both are 1, and `out_id` equals the identifier given with the profile.
- R4: The residual at index k is cos[k]·S + sin[k]·C − A·H[k], computed with full-precision signed products. S and C are IDX-independent signed DATA_W values, A is a signed AMP_W value and the table entries are signed TBL_W values.
- R5: The search first evaluates indices 0 and NBS−1. It then probes mid = floor((lo+hi)/2). If F(mid) has the same sign as F(lo), mid becomes lo; otherwise mid becomes hi. Zero counts as non-negative. The search stops when hi = lo+1.
- R6: Of the final pair, the index with the smaller |F| is reported. On a tie, the lower index lo is reported.
- R7: A write with `tbl_we`=1 stores `tbl_wdata` at `tbl_addr` in the table chosen by `tbl_sel`: 0 is cosine, 1 is sine, 2 is the harmonic term H, and 3 writes nothing. The write applies to every profile accepted afterwards.
- R8: A search uses at most IDX_W+2 evaluations of three cycles each, so `out_valid` rises no more than 3·(IDX_W+2) cycles after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Profile sums present |
| in_ready | output | 1 | Block can take a profile |
| in_sin_sum | input | DATA_W | Sine-weighted sum S (signed) |
| in_cos_sum | input | DATA_W | Cosine-weighted sum C (signed) |
| in_amp | input | AMP_W | Amplitude A (signed) |
| in_id | input | ID_W | Profile identifier |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_index | output | IDX_W | Chosen phase index |
| out_id | output | ID_W | Identifier of the result |
| busy | output | 1 | Search or unconsumed result pending |
| tbl_we | input | 1 | Table write strobe |
| tbl_sel | input | 2 | Table select (0 cos, 1 sin, 2 harmonic) |
| tbl_addr | input | IDX_W | Table entry index |
| tbl_wdata | input | TBL_W | Entry value (signed) |

## Verification
On every cycle, the assertions check four things. The result stays stable under back-pressure. Every midpoint probe lies strictly inside the current bracket. The reported index is one end of a bracket one step wide. The evaluator's fixed latency and the bound on the evaluation count are never exceeded. Some behaviour can only be shown by the directed scenarios, which compare against an independent model of the search. These are whether the arithmetic of the residual is right, whether the sign rule picks the correct half, the tie and no-crossing outcomes, and whether table writes reach later searches.

// File: rtl/bis_pkg.sv
package bis_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_DONE} bis_state_e;
  typedef enum logic [1:0] {EV_LO, EV_HI, EV_MID} bis_kind_e;
  localparam int unsigned NUM_TABLES = 3;
  localparam logic [1:0] TSEL_COS  = 2'd0;
  localparam logic [1:0] TSEL_SIN  = 2'd1;
  localparam logic [1:0] TSEL_HARM = 2'd2;
endpackage

// File: rtl/bis_tables.sv
module bis_tables #(
  parameter int unsigned IDX_W = 10,
  parameter int unsigned TBL_W = 18
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [1:0]              sel,
  input  logic [IDX_W-1:0]        waddr,
  input  logic signed [TBL_W-1:0] wdata,
  input  logic [IDX_W-1:0]        raddr,
  output logic signed [TBL_W-1:0] rd_cos,
  output logic signed [TBL_W-1:0] rd_sin,
  output logic signed [TBL_W-1:0] rd_harm
);
  import bis_pkg::*;
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic signed [TBL_W-1:0] rd_q [NUM_TABLES];

  // one synchronous-read memory per table; the read register feeds the multipliers
  for (genvar g = 0; g < NUM_TABLES; g++) begin : g_tab
    logic signed [TBL_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we && sel == 2'(g)) mem[waddr] <= wdata;
      rd_q[g] <= mem[raddr];
    end
  end

  assign rd_cos  = rd_q[TSEL_COS];
  assign rd_sin  = rd_q[TSEL_SIN];
  assign rd_harm = rd_q[TSEL_HARM];
endmodule

// File: rtl/bis_eval.sv
module bis_eval #(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned AMP_W  = 18,
  parameter int unsigned TBL_W  = 18,
  parameter int unsigned F_W    = DATA_W + TBL_W + 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req,
  input  logic signed [DATA_W-1:0] s_sum,
  input  logic signed [DATA_W-1:0] c_sum,
  input  logic signed [AMP_W-1:0]  amp,
  input  logic signed [TBL_W-1:0]  t_cos,
  input  logic signed [TBL_W-1:0]  t_sin,
  input  logic signed [TBL_W-1:0]  t_harm,
  output logic                     f_valid,
  output logic signed [F_W-1:0]    f_val
);
  logic rd_v;
  logic signed [F_W-1:0] p_cos, p_sin, p_harm;

  // operands sign-extended to the result width before multiplying
  assign p_cos  = F_W'(t_cos)  * F_W'(s_sum);
  assign p_sin  = F_W'(t_sin)  * F_W'(c_sum);
  assign p_harm = F_W'(t_harm) * F_W'(amp);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_v    <= 1'b0;
      f_valid <= 1'b0;
      f_val   <= '0;
    end else begin
      rd_v    <= req;
      f_valid <= rd_v;
      if (rd_v) f_val <= p_cos + p_sin - p_harm;
    end
  end

  // R8: every probe returns exactly two cycles after its request
  p_eval_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> ##2 f_valid);
  p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
    f_valid |-> $past(req, 2));
endmodule

// File: rtl/bis_ctrl.sv
module bis_ctrl #(
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned DATA_W = 24,
  parameter int unsigned AMP_W  = 18,
  parameter int unsigned ID_W   = 8,
  parameter int unsigned F_W    = 44
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic signed [DATA_W-1:0] in_s,
  input  logic signed [DATA_W-1:0] in_c,
  input  logic signed [AMP_W-1:0]  in_a,
  input  logic [ID_W-1:0]          in_id,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [IDX_W-1:0]         out_index,
  output logic [ID_W-1:0]          out_id,
  output logic                     busy,
  output logic [IDX_W-1:0]         rd_addr,
  output logic                     req,
  output logic signed [DATA_W-1:0] s_q,
  output logic signed [DATA_W-1:0] c_q,
  output logic signed [AMP_W-1:0]  a_q,
  input  logic                     f_valid,
  input  logic signed [F_W-1:0]    f_val
);
  import bis_pkg::*;
  localparam logic [IDX_W-1:0] IDX_MAX = '1;
  localparam int unsigned MAX_EVALS = IDX_W + 2;
  localparam int unsigned CNT_W = $clog2(MAX_EVALS + 2) + 1;

  bis_state_e st;
  bis_kind_e  kind;
  logic [IDX_W-1:0] lo, hi, cur, res, n_lo, n_hi, gap, mid, pick;
  logic signed [F_W-1:0] f_lo, f_hi, n_flo, n_fhi;
  logic [ID_W-1:0] id_q;
  logic done_now;
  logic [CNT_W-1:0] evals;

  function automatic logic [F_W-1:0] mag(input logic signed [F_W-1:0] v);
    return v[F_W-1] ? F_W'(-v) : F_W'(v);
  endfunction

  // bracket update for the residual that just arrived
  always_comb begin
    n_lo = lo; n_hi = hi; n_flo = f_lo; n_fhi = f_hi;
    case (kind)
      EV_LO: begin n_lo = cur; n_flo = f_val; end
      EV_HI: begin n_hi = cur; n_fhi = f_val; end
      EV_MID: begin
        if (f_val[F_W-1] == f_lo[F_W-1]) begin n_lo = cur; n_flo = f_val; end
        else begin n_hi = cur; n_fhi = f_val; end
      end
      default: ;
    endcase
    gap      = n_hi - n_lo;
    mid      = n_lo + (gap >> 1);
    done_now = (kind != EV_LO) && (gap <= IDX_W'(1));
    pick     = (mag(n_flo) <= mag(n_fhi)) ? n_lo : n_hi;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE; kind <= EV_LO;
      lo <= '0; hi <= '0; cur <= '0; res <= '0;
      f_lo <= '0; f_hi <= '0; id_q <= '0;
      s_q <= '0; c_q <= '0; a_q <= '0;
    end else begin
      case (st)
        ST_IDLE: if (in_valid) begin
          s_q <= in_s; c_q <= in_c; a_q <= in_a; id_q <= in_id;
          lo <= '0; hi <= IDX_MAX; cur <= '0; kind <= EV_LO;
          st <= ST_ISSUE;
        end
        ST_ISSUE: st <= ST_WAIT;
        ST_WAIT: if (f_valid) begin
          lo <= n_lo; hi <= n_hi; f_lo <= n_flo; f_hi <= n_fhi;
          if (kind == EV_LO) begin
            cur <= IDX_MAX; kind <= EV_HI; st <= ST_ISSUE;
          end else if (done_now) begin
            res <= pick; st <= ST_DONE;
          end else begin
            cur <= mid; kind <= EV_MID; st <= ST_ISSUE;
          end
        end
        ST_DONE: if (out_ready) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign in_ready  = (st == ST_IDLE);
  assign busy      = (st != ST_IDLE);
  assign out_valid = (st == ST_DONE);
  assign out_index = res;
  assign out_id    = id_q;
  assign req       = (st == ST_ISSUE);
  assign rd_addr   = cur;

  // evaluation counter for the step-bound check
  always_ff @(posedge clk) begin
    if (!rst_n) evals <= '0;
    else if (st == ST_IDLE) evals <= '0;
    else if (req) evals <= evals + 1'b1;
  end

  p_hold_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_index) && $stable(out_id));
  p_mid_inside_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ISSUE || st == ST_WAIT) && kind == EV_MID |-> cur > lo && cur < hi);
  p_final_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (hi == lo + IDX_W'(1)) && (out_index == lo || out_index == hi));
  p_step_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> evals < CNT_W'(MAX_EVALS));
endmodule

// File: rtl/phase_bisect.sv
module phase_bisect #(
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned TBL_W  = 18,
  parameter int unsigned DATA_W = 24,
  parameter int unsigned AMP_W  = 18,
  parameter int unsigned ID_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_sin_sum,
  input  logic [DATA_W-1:0] in_cos_sum,
  input  logic [AMP_W-1:0]  in_amp,
  input  logic [ID_W-1:0]   in_id,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [IDX_W-1:0]  out_index,
  output logic [ID_W-1:0]   out_id,
  output logic              busy,
  input  logic              tbl_we,
  input  logic [1:0]        tbl_sel,
  input  logic [IDX_W-1:0]  tbl_addr,
  input  logic [TBL_W-1:0]  tbl_wdata
);
  localparam int unsigned PROD_W = (DATA_W > AMP_W ? DATA_W : AMP_W) + TBL_W;
  localparam int unsigned F_W    = PROD_W + 2;

  logic [IDX_W-1:0] rd_addr;
  logic req, f_valid;
  logic signed [F_W-1:0] f_val;
  logic signed [DATA_W-1:0] s_q, c_q;
  logic signed [AMP_W-1:0] a_q;
  logic signed [TBL_W-1:0] t_cos, t_sin, t_harm;

  bis_tables #(.IDX_W(IDX_W), .TBL_W(TBL_W)) u_tab (
    .clk(clk), .we(tbl_we), .sel(tbl_sel), .waddr(tbl_addr),
    .wdata(tbl_wdata), .raddr(rd_addr),
    .rd_cos(t_cos), .rd_sin(t_sin), .rd_harm(t_harm));

  bis_eval #(.DATA_W(DATA_W), .AMP_W(AMP_W), .TBL_W(TBL_W), .F_W(F_W)) u_eval (
    .clk(clk), .rst_n(rst_n), .req(req), .s_sum(s_q), .c_sum(c_q), .amp(a_q),
    .t_cos(t_cos), .t_sin(t_sin), .t_harm(t_harm),
    .f_valid(f_valid), .f_val(f_val));

  bis_ctrl #(.IDX_W(IDX_W), .DATA_W(DATA_W), .AMP_W(AMP_W), .ID_W(ID_W), .F_W(F_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_s(in_sin_sum), .in_c(in_cos_sum), .in_a(in_amp), .in_id(in_id),
    .out_valid(out_valid), .out_ready(out_ready), .out_index(out_index),
    .out_id(out_id), .busy(busy), .rd_addr(rd_addr), .req(req),
    .s_q(s_q), .c_q(c_q), .a_q(a_q), .f_valid(f_valid), .f_val(f_val));
endmodule

// File: tb/sim_phase_bisect.sv
module sim_phase_bisect;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W = 10;
  localparam int NBS = 1 << IDX_W;
  localparam int MAX_LAT = 3 * (IDX_W + 2) + 2;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready, out_valid, out_ready = 0, busy;
  logic [23:0] in_sin_sum = 0, in_cos_sum = 0;
  logic [17:0] in_amp = 0;
  logic [7:0] in_id = 0, out_id;
  logic [IDX_W-1:0] out_index;
  logic tbl_we = 0;
  logic [1:0] tbl_sel = 0;
  logic [IDX_W-1:0] tbl_addr = 0;
  logic [17:0] tbl_wdata = 0;

  int checks = 0, errors = 0;
  bit finished = 0;
  longint tc [NBS], ts [NBS], th [NBS];

  always #(CLK_PERIOD/2) clk = ~clk;

  phase_bisect u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sin_sum(in_sin_sum), .in_cos_sum(in_cos_sum), .in_amp(in_amp), .in_id(in_id),
    .out_valid(out_valid), .out_ready(out_ready), .out_index(out_index), .out_id(out_id),
    .busy(busy), .tbl_we(tbl_we), .tbl_sel(tbl_sel), .tbl_addr(tbl_addr),
    .tbl_wdata(tbl_wdata));

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic longint resid(int k, longint s, longint c, longint a);
    return tc[k] * s + ts[k] * c - a * th[k];
  endfunction

  function automatic longint mag(longint v);
    return v < 0 ? -v : v;
  endfunction

  // independent model of the search rules (R5, R6)
  function automatic int model(longint s, longint c, longint a);
    int lo = 0, hi = NBS - 1;
    longint flo = resid(0, s, c, a), fhi = resid(NBS - 1, s, c, a);
    while (hi - lo > 1) begin
      int m = (lo + hi) / 2;
      longint fm = resid(m, s, c, a);
      if ((fm < 0) == (flo < 0)) begin lo = m; flo = fm; end
      else begin hi = m; fhi = fm; end
    end
    return (mag(flo) <= mag(fhi)) ? lo : hi;
  endfunction

  // mode 0: k, 1: constant 1, 2: zero, 3: 1000*cos(theta), 4: 1000*sin(theta)
  task automatic load_table(input int sel, input int mode);
    for (int k = 0; k < NBS; k++) begin
      real th_k = -3.14159265358979 + 2.0 * 3.14159265358979 * k / NBS;
      longint v;
      case (mode)
        0: v = k;
        1: v = 1;
        2: v = 0;
        3: v = longint'(1000.0 * $cos(th_k));
        default: v = longint'(1000.0 * $sin(th_k));
      endcase
      if (sel == 0) tc[k] = v; else if (sel == 1) ts[k] = v; else th[k] = v;
      @(negedge clk);
      tbl_we = 1; tbl_sel = 2'(sel); tbl_addr = IDX_W'(k); tbl_wdata = 18'(v);
    end
    @(negedge clk);
    tbl_we = 0;
  endtask

  task automatic run_search(input string rq, input longint s, input longint c, input longint a,
                            input int id, input int exp_fixed, input int hold);
    int exp, cnt;
    logic [IDX_W-1:0] first_idx;
    exp = model(s, c, a);
    if (exp_fixed >= 0) chk(exp == exp_fixed, {rq, " model"}, exp, exp_fixed);
    @(negedge clk);
    in_valid = 1; in_sin_sum = 24'(s); in_cos_sum = 24'(c); in_amp = 18'(a); in_id = 8'(id);
    @(posedge clk);
    @(negedge clk);
    in_valid = 0; in_id = 8'hEE;
    chk(busy && !in_ready, "R2 busy after accept", {busy, in_ready}, 2);
    cnt = 1;
    while (!out_valid && cnt < 200) begin @(negedge clk); cnt++; end
    chk(cnt <= MAX_LAT, "R8 latency", cnt, MAX_LAT);
    chk(out_index == IDX_W'(exp), {rq, " index"}, out_index, exp);
    chk(out_id == 8'(id), "R3 id", out_id, id);
    first_idx = out_index;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(out_valid && out_index == first_idx && !in_ready, "R3 hold", out_index, first_idx);
    end
    out_ready = 1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 0;
    chk(!out_valid && in_ready && !busy, "R2 released", {out_valid, in_ready}, 1);
  endtask

  task automatic t_reset;
    chk(!out_valid && !busy && in_ready, "R1 reset state", {out_valid, busy, in_ready}, 1);
  endtask

  task automatic t_linear;
    load_table(0, 0); load_table(1, 1); load_table(2, 2);
    run_search("R5 exact zero", 1, -300, 0, 11, 300, 0);
    run_search("R6 tie low", 2, -601, 0, 12, 300, 0);
    run_search("R6 nearer high", 4, -1203, 0, 13, 301, 0);
    run_search("R5 falling", -3, 1500, 0, 14, 500, 3);
    run_search("R5 no crossing", 1, 100, 0, 15, 1022, 0);
  endtask

  task automatic t_amp;
    load_table(2, 0);
    run_search("R4 amplitude term", 5, -800, 3, 21, 400, 0);
    // R7: unused select 3 must leave all tables untouched
    @(negedge clk);
    tbl_we = 1; tbl_sel = 2'd3; tbl_addr = IDX_W'(400); tbl_wdata = 18'h1234;
    @(negedge clk);
    tbl_we = 0;
    run_search("R7 select 3 ignored", 5, -800, 3, 22, 400, 0);
  endtask

  task automatic t_trig;
    load_table(0, 3); load_table(1, 4); load_table(2, 2);
    run_search("R4 trig residual", -500, 866, 0, 31, -1, 2);
    run_search("R5 trig second", 707, -707, 0, 32, -1, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_linear();
    t_amp();
    t_trig();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule